// File: doc/BRIEF.md
# LFSR Challenge Scrambler

This block turns a single loaded challenge into a stream of oscillator-pair selection words. A load strobe captures the challenge twice. One copy seeds a maximum-length Fibonacci shift register. The other copy is held unchanged for the rest of the response. Each shift strobe moves the shift register one step. The word presented at the outputs is always the current register state XORed with the held challenge.

The XOR with the held challenge is what separates two challenges that are neighbours in the register's cycle. Without it, their selection streams would be the same stream offset by one step. With it, the streams differ.

The registered selection word is split into two equal halves. Each half addresses one bank of ring oscillators, through that bank's enable demultiplexer and its count multiplexer. The oscillators and the sequencing controller sit outside this block. The controller issues one load per response, then one shift per response bit.

Top module: `chal_scrambler`

## Requirements
- R1: After reset, the selection word (sel_b concatenated above sel_a) is 10'h001: the shift register holds the fixed nonzero seed 10'h001 and the held challenge is zero.
- R2: One cycle after `load` is sampled high with a nonzero `chal`, the register state and the held copy both equal `chal`, so the selection word is 10'h000.
- R3: One cycle after `load` is sampled high with `chal` equal to zero, the register state is the fixed seed 10'h001 and the held copy is zero, so the selection word is 10'h001.
- R4: One cycle after `shift` is sampled high and `load` low, the state becomes {s[8:0], s[9]^s[6]} (polynomial x^10+x^7+1, shifting toward the MSB, feedback into bit 0). The word becomes that new state XOR the held challenge, so it always differs from the previous word.
- R5: While `load` and `shift` are both low, the selection word does not change.
- R6: When `load` and `shift` are sampled high in the same cycle, the load takes effect and no step is made.
- R7: The state sequence has period 1023: after 1023 shifts from a load, the word returns to its value right after the load, and it reaches that value at no earlier step.
- R8: `sel_a` carries word bits 4:0 (oscillator A select) and `sel_b` carries word bits 9:5 (oscillator B select).
- R9: For a challenge X and its successor Y = next(X) in the register cycle, the words produced by the first eight shifts after loading Y are not the words produced by shifts two to nine after loading X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture `chal` as seed and held copy |
| shift | input | 1 | Advance the shift register one step |
| chal | input | SEL_W (10) | Challenge value |
| sel_a | output | SEL_W/2 (5) | Oscillator A bank select (word low half) |
| sel_b | output | SEL_W/2 (5) | Oscillator B bank select (word high half) |

## Verification
The bench builds the block with its default values: a 10-bit word, feedback taps on bits 9 and 6, and seed 10'h001 for the all-zero challenge. With only 1023 states, a complete walk around the cycle fits easily in one run. That walk checks every word of the cycle against an independent model, and it shows that the word first returns to its starting value at exactly step 1023. The same width makes it cheap to compare full short streams for a challenge and its successor, and to exercise the zero challenge, simultaneous load and shift, and idle cycles.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [1:0] {
    SCR_KEEP = 2'd0,
    SCR_SEED = 2'd1,
    SCR_STEP = 2'd2
  } scr_op_e;

  // load wins over shift
  function automatic scr_op_e scr_decode(input logic ld, input logic sh);
    if (ld)      return SCR_SEED;
    else if (sh) return SCR_STEP;
    else         return SCR_KEEP;
  endfunction

endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr
  import scr_pkg::*;
#(
  parameter int          W          = 10,
  parameter logic [W-1:0] TAPS      = 10'h240,
  parameter logic [W-1:0] ZERO_SEED = 10'h001,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  scr_op_e      op,
  input  logic [W-1:0] chal,
  output logic [W-1:0] state_d
);

  logic [W-1:0] state_q;
  logic [W-1:0] seed_val;
  logic         fb;

  generate
    if (ZERO_GUARD) begin : g_guard
      assign seed_val = (chal == '0) ? ZERO_SEED : chal;
    end else begin : g_raw
      assign seed_val = chal;
    end
  endgenerate

  assign fb = ^(state_q & TAPS);

  always_comb begin
    case (op)
      SCR_SEED: state_d = seed_val;
      SCR_STEP: state_d = {state_q[W-2:0], fb};
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ZERO_SEED;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/scr_hold.sv
module scr_hold
  import scr_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  scr_op_e      op,
  input  logic [W-1:0] chal,
  output logic [W-1:0] hold_d
);

  logic [W-1:0] hold_q;

  assign hold_d = (op == SCR_SEED) ? chal : hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= hold_d;
  end

endmodule

// File: rtl/scr_mix.sv
module scr_mix #(
  parameter int           W       = 10,
  parameter logic [W-1:0] RST_VAL = 10'h001,
  localparam int          HALF_W  = W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      state_d,
  input  logic [W-1:0]      hold_d,
  output logic [HALF_W-1:0] lo,
  output logic [HALF_W-1:0] hi
);

  logic [W-1:0]             word_q;
  logic [1:0][HALF_W-1:0]   lane;

  always_ff @(posedge clk) begin
    if (rst) word_q <= RST_VAL;
    else     word_q <= state_d ^ hold_d;
  end

  generate
    for (genvar h = 0; h < 2; h++) begin : g_lane
      assign lane[h] = word_q[h*HALF_W +: HALF_W];
    end
  endgenerate

  assign lo = lane[0];
  assign hi = lane[1];

endmodule

// File: rtl/chal_scrambler.sv
module chal_scrambler
  import scr_pkg::*;
#(
  parameter int               SEL_W     = 10,
  parameter logic [SEL_W-1:0] TAPS      = 10'h240,
  parameter logic [SEL_W-1:0] ZERO_SEED = 10'h001,
  localparam int              HALF_W    = SEL_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [SEL_W-1:0]  chal,
  output logic [HALF_W-1:0] sel_a,
  output logic [HALF_W-1:0] sel_b
);

  scr_op_e          op;
  logic [SEL_W-1:0] state_d;
  logic [SEL_W-1:0] hold_d;

  assign op = scr_decode(load, shift);

  scr_lfsr #(.W(SEL_W), .TAPS(TAPS), .ZERO_SEED(ZERO_SEED), .ZERO_GUARD(1'b1)) u_lfsr (
    .clk(clk), .rst(rst), .op(op), .chal(chal), .state_d(state_d)
  );

  scr_hold #(.W(SEL_W)) u_hold (
    .clk(clk), .rst(rst), .op(op), .chal(chal), .hold_d(hold_d)
  );

  scr_mix #(.W(SEL_W), .RST_VAL(ZERO_SEED)) u_mix (
    .clk(clk), .rst(rst), .state_d(state_d), .hold_d(hold_d),
    .lo(sel_a), .hi(sel_b)
  );

endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
  parameter int               W         = 10,
  parameter logic [W-1:0]     ZERO_SEED = 10'h001,
  localparam int              HALF_W    = W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              shift,
  input logic [W-1:0]      chal,
  input logic [HALF_W-1:0] sel_a,
  input logic [HALF_W-1:0] sel_b
);

  logic [W-1:0] word;
  assign word = {sel_b, sel_a};

  // R2
  load_nonzero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (load && chal != '0) |=> (word == '0));

  // R3
  load_zero_seeds_chk: assert property (@(posedge clk) disable iff (rst)
    (load && chal == '0) |=> (word == ZERO_SEED));

  // R4
  shift_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && shift) |=> (word != $past(word)));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(word));

  // R6
  load_beats_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (load && shift && chal != '0) |=> (word == '0));

endmodule

bind chal_scrambler scr_chk #(.W(SEL_W), .ZERO_SEED(ZERO_SEED)) u_scr_chk (
  .clk(clk), .rst(rst), .load(load), .shift(shift), .chal(chal),
  .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/chal_scrambler_test.sv
module chal_scrambler_test;

  localparam int W = 10;
  localparam int H = W / 2;

  typedef struct {
    logic [W-1:0] word;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic         shift = 1'b0;
  logic [W-1:0] chal = '0;
  logic [H-1:0] sel_a;
  logic [H-1:0] sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exp_t         sb[$];
  logic [W-1:0] m_state = 10'h001;
  logic [W-1:0] m_hold  = '0;
  logic [W-1:0] obs;
  logic [W-1:0] run_x[0:9];
  logic [W-1:0] run_y[0:9];

  chal_scrambler uut (
    .clk(clk), .rst(rst), .load(load), .shift(shift), .chal(chal),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  always #2 clk = ~clk;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[W-2:0], s[9] ^ s[6]};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one clocked operation, expected word pushed to scoreboard
  task automatic op(input logic ld, input logic sh, input logic [W-1:0] c, input string tag);
    @(negedge clk);
    load = ld; shift = sh; chal = c;
    if (ld) begin
      m_state = (c == '0) ? 10'h001 : c;
      m_hold  = c;
    end else if (sh) begin
      m_state = nxt(m_state);
    end
    @(posedge clk);
    #1;
    obs = {sel_b, sel_a};
    sb.push_back('{word: m_state ^ m_hold, tag: tag});
    load = 1'b0; shift = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, {sel_b, sel_a}, e.word);
        check("R8 sel_a low half", {5'b0, sel_a}, {5'b0, e.word[4:0]});
        check("R8 sel_b high half", {5'b0, sel_b}, {5'b0, e.word[9:5]});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] start;
    logic [W-1:0] x;
    logic         early;
    bit           differ;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", {sel_b, sel_a}, 10'h001);

    // R2 then R4 steps
    op(1, 0, 10'h2A5, "R2 load nonzero");
    for (int i = 0; i < 20; i++) op(0, 1, '0, "R4 step");
    // R5 idle
    for (int i = 0; i < 4; i++) op(0, 0, 10'h3FF, "R5 idle hold");
    // R6 simultaneous
    op(1, 1, 10'h0C3, "R6 load beats shift");
    op(0, 1, '0, "R4 step after R6");
    // R3 zero challenge
    op(1, 0, 10'h000, "R3 zero challenge");
    for (int i = 0; i < 12; i++) op(0, 1, '0, "R4 step from guard seed");

    // R7 full period
    op(1, 0, 10'h155, "R2 load for period");
    start = obs;
    early = 1'b0;
    for (int i = 1; i <= 1023; i++) begin
      op(0, 1, '0, "R7 period walk");
      if (i < 1023 && obs == start) early = 1'b1;
    end
    check("R7 return at 1023", obs, start);
    check("R7 no early return", {9'b0, early}, 10'h000);

    // R9 neighbour challenges
    x = 10'h0F3;
    op(1, 0, x, "R2 load X");
    for (int i = 0; i < 10; i++) begin
      op(0, 1, '0, "R9 stream X");
      run_x[i] = obs;
    end
    op(1, 0, nxt(x), "R2 load Y");
    for (int i = 0; i < 8; i++) begin
      op(0, 1, '0, "R9 stream Y");
      run_y[i] = obs;
    end
    differ = 1'b0;
    for (int i = 0; i < 8; i++) if (run_y[i] != run_x[i+1]) differ = 1'b1;
    check("R9 neighbour streams differ", {9'b0, differ}, 10'h001);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule